// File: doc/BRIEF.md
# CRC-Guarded Register Access Engine

This block is the target side of a register access protocol carried over a byte-oriented two-wire serial link. A byte-level bus front end, which is not part of this block, handles the bit-level signalling. It passes the engine start and stop events and a one-cycle byte strobe, together with the received byte and a direction flag. When the direction flag is high, the strobe means that the byte on `tx_byte` has just been shifted out to the controller.

Every burst is guarded by a CRC-8 over the whole transaction, including the 8-bit device address byte. The register address byte carries both the starting offset and the burst length. Write data is held in a small buffer and goes to the register file only after the received CRC has been checked. Reads return the requested bytes followed by a CRC that the engine computes while the data goes out. Errors are reported on two sticky flags, which software clears with a one-cycle pulse.

Top module: `crcreg_engine`

## Requirements
- R1: A frame whose device address byte has bits [7:1] different from the `DEV_ADDR` parameter is ignored until the next start: `selected` stays 0, no register is written and `tx_byte` stays 0xFF. After a matching device byte, `selected` is 1.
- R2: In the register address byte, bits [5:0] give the starting offset and bits [7:6] give the burst length minus one. Codes 0, 1, 2 and 3 select 1, 2, 3 and 4 data bytes, and the offset advances by one for each byte of the burst.
- R3: The CRC is CRC-8 with polynomial 0x07, shifted MSB first, with initial value 0x00, no reflection and no final XOR. It runs over the device address byte ({address, R/W}), then the register address byte, then the data bytes.
- R4: A write frame is the device byte with R/W=0, the register address byte, N data bytes, the CRC byte and one dummy byte whose value is ignored. When the CRC matches, the N bytes are written one per cycle in ascending offset order, starting the cycle after the CRC byte strobe.
- R5: When the received write CRC does not match, no register is written and `err_crc` is set. It stays set until `err_clr` is pulsed.
- R6: A stop or a repeated start that arrives before the CRC byte abandons the write: nothing is written and no flag is set.
- R7: A read sequence is the device byte with R/W=0, the register address byte, a repeated start, then the device byte with R/W=1. The engine then returns the N bytes from the offset upward, then the CRC (computed with R/W=1 in the device byte), then 0xFF for any further byte.
- R8: A register address byte whose burst would touch an offset at or above `REG_COUNT` sets `err_range`. No write follows, and a read with that address returns only 0xFF.
- R9: A read issued after a stop, without a new register address byte, returns only 0xFF.
- R10: After reset, `tx_byte` is 0xFF and `selected`, `err_crc`, `err_range` and `rf_we` are 0. A pulse on `err_clr` returns both flags to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_start | input | 1 | One-cycle pulse on a start or repeated start |
| bus_stop | input | 1 | One-cycle pulse on a stop |
| bus_strobe | input | 1 | One-cycle byte event |
| bus_dir | input | 1 | 0: byte received on `bus_rx_byte`; 1: `tx_byte` was sent |
| bus_rx_byte | input | 8 | Byte received from the controller |
| tx_byte | output | 8 | Byte to be sent on the next read slot |
| selected | output | 1 | Engine addressed in the current frame (front end acknowledges) |
| err_clr | input | 1 | Clears both error flags |
| err_crc | output | 1 | Sticky write CRC mismatch flag |
| err_range | output | 1 | Sticky out-of-range burst flag |
| rf_we | output | 1 | Register file write enable |
| rf_waddr | output | 6 | Register file write offset |
| rf_wdata | output | 8 | Register file write data |
| rf_raddr | output | 6 | Register file read offset |
| rf_rdata | input | 8 | Register file read data for `rf_raddr`, same cycle |

## Verification
Several properties are checked on every cycle. A commit may start only in the cycle after an accepted CRC, and it lasts no longer than one burst. Every write offset lies inside the register range. The error flags hold until they are cleared, and no write happens in the cycle a CRC error is raised. The send byte stays 0xFF whenever the engine is not addressed, and a stop returns the engine to idle. Other behaviour can be shown only by the bench's scenarios: the CRC values themselves, the order and contents of committed writes, the abandoned bursts, the range boundary and the read data and trailer bytes. The bench compares these against a register model and a CRC function of its own.

// File: rtl/crcreg_pkg.sv
`timescale 1ns/1ps
package crcreg_pkg;
   localparam int BYTE_W    = 8;
   localparam int OFS_W     = 6;
   localparam int LEN_W     = 2;
   localparam int MAX_BURST = 1 << LEN_W;
   localparam logic [BYTE_W-1:0] FILL_BYTE = 8'hFF;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_DEV,
      ST_REG,
      ST_WDAT,
      ST_WCRC,
      ST_WTAIL,
      ST_RD,
      ST_SKIP
   } crcreg_state_e;
endpackage

// File: rtl/crcreg_crc_step.sv
`timescale 1ns/1ps
// One byte of CRC-8, MSB first, no reflection.
module crcreg_crc_step #(
   parameter logic [7:0] POLY = 8'h07
) (
   input  logic [7:0] crc_in,
   input  logic [7:0] data_in,
   output logic [7:0] crc_out
);
   logic [7:0] acc;

   always_comb begin
      acc = crc_in ^ data_in;
      for (int b = 0; b < 8; b++) begin
         acc = acc[7] ? ({acc[6:0], 1'b0} ^ POLY) : {acc[6:0], 1'b0};
      end
      crc_out = acc;
   end
endmodule

// File: rtl/crcreg_wr_commit.sv
`timescale 1ns/1ps
// Holds the write burst and drains it into the register file once released.
module crcreg_wr_commit #(
   parameter int OFS_W = 6,
   parameter int DEPTH = 4
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      cap_en,
   input  logic [$clog2(DEPTH)-1:0]  cap_idx,
   input  logic [7:0]                cap_data,
   input  logic                      go,
   input  logic [OFS_W-1:0]          base,
   input  logic [$clog2(DEPTH)-1:0]  last,
   output logic                      we,
   output logic [OFS_W-1:0]          waddr,
   output logic [7:0]                wdata
);
   localparam int IDX_W = $clog2(DEPTH);

   logic [7:0]       slot [DEPTH];
   logic             active_q;
   logic [IDX_W-1:0] idx_q;
   logic [IDX_W-1:0] last_q;
   logic [OFS_W-1:0] base_q;
   logic [IDX_W:0]   run_q;

   for (genvar e = 0; e < DEPTH; e++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            slot[e] <= '0;
         end else if (cap_en && cap_idx == IDX_W'(e)) begin
            slot[e] <= cap_data;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         idx_q    <= '0;
         last_q   <= '0;
         base_q   <= '0;
      end else if (go) begin
         active_q <= 1'b1;
         idx_q    <= '0;
         last_q   <= last;
         base_q   <= base;
      end else if (active_q) begin
         if (idx_q == last_q) begin
            active_q <= 1'b0;
         end else begin
            idx_q <= idx_q + 1'b1;
         end
      end
   end

   assign we    = active_q;
   assign waddr = base_q + OFS_W'(idx_q);
   assign wdata = slot[idx_q];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= '0;
      end else if (we) begin
         run_q <= run_q + 1'b1;
      end else begin
         run_q <= '0;
      end
   end

   // R4: a commit never runs longer than one burst
   assert_burst_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
      we |-> (run_q < (IDX_W+1)'(DEPTH)));
endmodule

// File: rtl/crcreg_rd_mux.sv
`timescale 1ns/1ps
// Chooses the byte to send: register data, then the CRC, then fill.
module crcreg_rd_mux #(
   parameter int          OFS_W = 6,
   parameter int          LEN_W = 2,
   parameter logic [7:0]  FILL  = 8'hFF
) (
   input  logic             active,
   input  logic [OFS_W-1:0] base,
   input  logic [LEN_W-1:0] len,
   input  logic [LEN_W:0]   cnt,
   input  logic [7:0]       crc,
   input  logic [7:0]       rf_rdata,
   output logic [7:0]       tx_byte,
   output logic [OFS_W-1:0] raddr
);
   localparam int CNT_W = LEN_W + 1;

   logic data_phase;
   logic crc_phase;

   assign data_phase = cnt <= CNT_W'(len);
   assign crc_phase  = cnt == (CNT_W'(len) + 1'b1);
   assign raddr      = base + OFS_W'(cnt);

   always_comb begin
      if (!active)         tx_byte = FILL;
      else if (data_phase) tx_byte = rf_rdata;
      else if (crc_phase)  tx_byte = crc;
      else                 tx_byte = FILL;
   end
endmodule

// File: rtl/crcreg_engine.sv
`timescale 1ns/1ps
module crcreg_engine
   import crcreg_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR  = 7'h2A,
   parameter int         REG_COUNT = 48,
   parameter logic [7:0] CRC_POLY  = 8'h07
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_start,
   input  logic             bus_stop,
   input  logic             bus_strobe,
   input  logic             bus_dir,
   input  logic [7:0]       bus_rx_byte,
   output logic [7:0]       tx_byte,
   output logic             selected,
   input  logic             err_clr,
   output logic             err_crc,
   output logic             err_range,
   output logic             rf_we,
   output logic [OFS_W-1:0] rf_waddr,
   output logic [7:0]       rf_wdata,
   output logic [OFS_W-1:0] rf_raddr,
   input  logic [7:0]       rf_rdata
);
   localparam int CNT_W  = LEN_W + 1;
   localparam int SPAN_W = OFS_W + 1;

   if (REG_COUNT < 1 || REG_COUNT > (1 << OFS_W)) begin : g_bad_count
      $error("REG_COUNT must lie in 1 .. 2**OFS_W");
   end
   if (CRC_POLY[0] != 1'b1) begin : g_bad_poly
      $error("CRC_POLY must have its constant term set");
   end

   crcreg_state_e    state_q;
   logic [7:0]       reg_q;
   logic             reg_valid_q;
   logic [CNT_W-1:0] cnt_q;
   logic [7:0]       crc_q;
   logic             err_crc_q;
   logic             err_range_q;

   logic             byte_ok, rx_fire, tx_fire, dev_hit;
   logic [7:0]       crc_seed, crc_dat, crc_a, crc_b;
   logic [SPAN_W-1:0] span;
   logic             range_bad;
   logic             cap_en, commit_go;
   logic [OFS_W-1:0] cur_off;
   logic [LEN_W-1:0] cur_len;

   assign byte_ok   = bus_strobe && !bus_start && !bus_stop;
   assign rx_fire   = byte_ok && !bus_dir;
   assign tx_fire   = byte_ok && bus_dir;
   assign dev_hit   = bus_rx_byte[7:1] == DEV_ADDR;
   assign cur_off   = reg_q[OFS_W-1:0];
   assign cur_len   = reg_q[7 -: LEN_W];
   assign span      = SPAN_W'(bus_rx_byte[OFS_W-1:0]) + SPAN_W'(bus_rx_byte[7 -: LEN_W]);
   assign range_bad = span >= SPAN_W'(REG_COUNT);

   assign crc_seed = (state_q == ST_DEV) ? 8'h00 : crc_q;
   assign crc_dat  = bus_dir ? tx_byte : bus_rx_byte;

   crcreg_crc_step #(.POLY(CRC_POLY)) u_crc_a (
      .crc_in(crc_seed), .data_in(crc_dat), .crc_out(crc_a)
   );
   crcreg_crc_step #(.POLY(CRC_POLY)) u_crc_b (
      .crc_in(crc_a), .data_in(reg_q), .crc_out(crc_b)
   );

   assign cap_en    = (state_q == ST_WDAT) && rx_fire;
   assign commit_go = (state_q == ST_WCRC) && rx_fire && (bus_rx_byte == crc_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         reg_q       <= '0;
         reg_valid_q <= 1'b0;
         cnt_q       <= '0;
         crc_q       <= '0;
         err_crc_q   <= 1'b0;
         err_range_q <= 1'b0;
      end else begin
         if (err_clr) begin
            err_crc_q   <= 1'b0;
            err_range_q <= 1'b0;
         end
         if (bus_start) begin
            state_q <= ST_DEV;
         end else if (bus_stop) begin
            state_q     <= ST_IDLE;
            reg_valid_q <= 1'b0;
         end else begin
            unique case (state_q)
               ST_DEV: if (rx_fire) begin
                  if (!dev_hit) begin
                     state_q <= ST_SKIP;
                  end else if (!bus_rx_byte[0]) begin
                     state_q     <= ST_REG;
                     reg_valid_q <= 1'b0;
                     crc_q       <= crc_a;
                  end else begin
                     state_q <= ST_RD;
                     crc_q   <= crc_b;
                     cnt_q   <= '0;
                  end
               end
               ST_REG: if (rx_fire) begin
                  reg_q <= bus_rx_byte;
                  if (range_bad) begin
                     err_range_q <= 1'b1;
                     state_q     <= ST_SKIP;
                  end else begin
                     reg_valid_q <= 1'b1;
                     crc_q       <= crc_a;
                     cnt_q       <= '0;
                     state_q     <= ST_WDAT;
                  end
               end
               ST_WDAT: if (rx_fire) begin
                  crc_q <= crc_a;
                  if (cnt_q[LEN_W-1:0] == cur_len) begin
                     state_q <= ST_WCRC;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
               ST_WCRC: if (rx_fire) begin
                  if (commit_go) begin
                     state_q <= ST_WTAIL;
                  end else begin
                     err_crc_q <= 1'b1;
                     state_q   <= ST_SKIP;
                  end
               end
               ST_RD: if (tx_fire && reg_valid_q) begin
                  if (cnt_q <= CNT_W'(cur_len)) begin
                     crc_q <= crc_a;
                  end
                  if (cnt_q != CNT_W'(cur_len) + CNT_W'(2)) begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
               default: ;
            endcase
         end
      end
   end

   crcreg_wr_commit #(.OFS_W(OFS_W), .DEPTH(MAX_BURST)) u_commit (
      .clk      (clk),
      .rst_n    (rst_n),
      .cap_en   (cap_en),
      .cap_idx  (cnt_q[LEN_W-1:0]),
      .cap_data (bus_rx_byte),
      .go       (commit_go),
      .base     (cur_off),
      .last     (cur_len),
      .we       (rf_we),
      .waddr    (rf_waddr),
      .wdata    (rf_wdata)
   );

   crcreg_rd_mux #(.OFS_W(OFS_W), .LEN_W(LEN_W), .FILL(FILL_BYTE)) u_rdmux (
      .active   ((state_q == ST_RD) && reg_valid_q),
      .base     (cur_off),
      .len      (cur_len),
      .cnt      (cnt_q),
      .crc      (crc_q),
      .rf_rdata (rf_rdata),
      .tx_byte  (tx_byte),
      .raddr    (rf_raddr)
   );

   assign selected  = (state_q == ST_REG) || (state_q == ST_WDAT) || (state_q == ST_WCRC) ||
                      (state_q == ST_WTAIL) || (state_q == ST_RD);
   assign err_crc   = err_crc_q;
   assign err_range = err_range_q;

   // R4: a commit starts only right after an accepted CRC byte
   assert_commit_after_crc_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rf_we) |-> $past(commit_go));
   // R5: the CRC flag holds until cleared
   assert_crc_flag_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
      err_crc && !err_clr |=> err_crc);
   // R5: no write in the cycle a CRC error is raised
   assert_no_write_on_error_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_crc) |-> !rf_we);
   // R8: every write lands inside the register range
   assert_waddr_in_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rf_we |-> (SPAN_W'(rf_waddr) < SPAN_W'(REG_COUNT)));
   // R8: the range flag holds until cleared
   assert_range_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      err_range && !err_clr |=> err_range);
   // R1: an unaddressed engine only sends fill bytes
   assert_idle_fill_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !selected |-> tx_byte == FILL_BYTE);
   // R6: a stop returns the engine to idle
   assert_stop_to_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      bus_stop && !bus_start |=> !selected && state_q == ST_IDLE);
endmodule

// File: tb/crcreg_engine_test.sv
`timescale 1ns/1ps
module crcreg_engine_test;
   localparam logic [6:0] DEV   = 7'h2A;
   localparam logic [6:0] OTHER = 7'h15;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_start = 1'b0, bus_stop = 1'b0, bus_strobe = 1'b0, bus_dir = 1'b0;
   logic       err_clr = 1'b0;
   logic [7:0] bus_rx_byte = 8'h00;
   logic [7:0] tx_byte, rf_wdata, rf_rdata;
   logic       selected, err_crc, err_range, rf_we;
   logic [5:0] rf_waddr, rf_raddr;

   always #10 clk = ~clk;

   crcreg_engine uut (
      .clk(clk), .rst_n(rst_n), .bus_start(bus_start), .bus_stop(bus_stop),
      .bus_strobe(bus_strobe), .bus_dir(bus_dir), .bus_rx_byte(bus_rx_byte),
      .tx_byte(tx_byte), .selected(selected), .err_clr(err_clr),
      .err_crc(err_crc), .err_range(err_range), .rf_we(rf_we),
      .rf_waddr(rf_waddr), .rf_wdata(rf_wdata), .rf_raddr(rf_raddr),
      .rf_rdata(rf_rdata)
   );

   // register file model
   logic [7:0] mem [64];
   logic [7:0] shadow [64];
   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 64; i++) mem[i] <= 8'(i * 13 + 7);
      end else if (rf_we) begin
         mem[rf_waddr] <= rf_wdata;
      end
   end
   assign rf_rdata = mem[rf_raddr];

   int nchk = 0, nfail = 0;
   bit done = 0;
   logic [13:0] exp_q [$];
   logic [13:0] mon_e;
   logic [7:0]  wd [4];

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [7:0] crc_upd(input logic [7:0] c, input logic [7:0] d);
      logic [7:0] x;
      x = c ^ d;
      for (int i = 0; i < 8; i++) x = x[7] ? ({x[6:0], 1'b0} ^ 8'h07) : {x[6:0], 1'b0};
      return x;
   endfunction

   // scoreboard monitor: every register write must match the next expected item
   always @(negedge clk) begin
      if (rst_n && rf_we) begin
         if (exp_q.size() == 0) begin
            chk("R4", "unexpected write offset", {26'd0, rf_waddr}, 32'hFFFF);
         end else begin
            mon_e = exp_q.pop_front();
            chk("R4", "write offset", {26'd0, rf_waddr}, {26'd0, mon_e[13:8]});
            chk("R4", "write data", {24'd0, rf_wdata}, {24'd0, mon_e[7:0]});
         end
      end
   end

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask
   task automatic pulse_start;
      @(negedge clk); bus_start = 1'b1;
      @(negedge clk); bus_start = 1'b0;
      idle(2);
   endtask
   task automatic pulse_stop;
      @(negedge clk); bus_stop = 1'b1;
      @(negedge clk); bus_stop = 1'b0;
      idle(2);
   endtask
   task automatic send(input logic [7:0] b);
      @(negedge clk); bus_strobe = 1'b1; bus_dir = 1'b0; bus_rx_byte = b;
      @(negedge clk); bus_strobe = 1'b0;
      idle(2);
   endtask
   task automatic take(output logic [7:0] b);
      @(negedge clk); b = tx_byte; bus_strobe = 1'b1; bus_dir = 1'b1;
      @(negedge clk); bus_strobe = 1'b0; bus_dir = 1'b0;
      idle(2);
   endtask

   task automatic write_frame(input logic [6:0] dev, input logic [5:0] off, input int n,
                              input bit bad, input logic [7:0] dummy, input int cut,
                              input bit commit, input string tag);
      logic [7:0] c, rb;
      rb = {2'(n - 1), off};
      pulse_start;
      send({dev, 1'b0});
      c = crc_upd(8'h00, {dev, 1'b0});
      chk("R1", {tag, " selected"}, {31'd0, selected}, {31'd0, dev == DEV});
      send(rb);
      c = crc_upd(c, rb);
      for (int i = 0; i < n; i++) begin
         if (i == cut) begin
            pulse_stop;
            idle(6);
            chk(tag, "writes left after abort", exp_q.size(), 0);
            return;
         end
         send(wd[i]);
         c = crc_upd(c, wd[i]);
      end
      if (commit) begin
         for (int i = 0; i < n; i++) begin
            exp_q.push_back({off + 6'(i), wd[i]});
            shadow[off + 6'(i)] = wd[i];
         end
      end
      send(bad ? (c ^ 8'h01) : c);
      send(dummy);
      pulse_stop;
      idle(6);
      chk(tag, "writes left after frame", exp_q.size(), 0);
   endtask

   task automatic read_frame(input logic [5:0] off, input int n, input int extra,
                             input bit all_ff, input string tag);
      logic [7:0] c, rb, b, e;
      rb = {2'(n - 1), off};
      pulse_start;
      send({DEV, 1'b0});
      send(rb);
      pulse_start;
      send({DEV, 1'b1});
      c = crc_upd(crc_upd(8'h00, {DEV, 1'b1}), rb);
      for (int i = 0; i < n; i++) begin
         take(b);
         e = all_ff ? 8'hFF : shadow[off + 6'(i)];
         chk(tag, "read data", {24'd0, b}, {24'd0, e});
         c = crc_upd(c, e);
      end
      take(b);
      chk(all_ff ? tag : "R3", "read crc", {24'd0, b}, {24'd0, all_ff ? 8'hFF : c});
      for (int i = 0; i < extra; i++) begin
         take(b);
         chk("R7", "byte past crc", {24'd0, b}, 32'hFF);
      end
      pulse_stop;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         nfail++;
         $display("FAIL watchdog: run did not finish");
         $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
         $finish;
      end
   end

   initial begin
      logic [7:0] b;
      for (int i = 0; i < 64; i++) shadow[i] = 8'(i * 13 + 7);
      idle(5);
      rst_n = 1'b1;
      idle(2);
      // R10 reset state
      chk("R10", "tx_byte", {24'd0, tx_byte}, 32'hFF);
      chk("R10", "err_crc", {31'd0, err_crc}, 0);
      chk("R10", "err_range", {31'd0, err_range}, 0);
      chk("R10", "rf_we", {31'd0, rf_we}, 0);
      chk("R10", "selected", {31'd0, selected}, 0);

      // R2 / R4: single byte write, then read back with CRC (R3, R7)
      wd[0] = 8'h3C;
      write_frame(DEV, 6'd5, 1, 1'b0, 8'h00, -1, 1'b1, "R4");
      read_frame(6'd5, 1, 2, 1'b0, "R7");

      // R4: four byte burst with a nonzero dummy byte
      wd[0] = 8'hA1; wd[1] = 8'hB2; wd[2] = 8'hC3; wd[3] = 8'hD4;
      write_frame(DEV, 6'd10, 4, 1'b0, 8'hA5, -1, 1'b1, "R4");
      read_frame(6'd10, 4, 2, 1'b0, "R7");
      // R2: length code 2 means three bytes, offset advances
      read_frame(6'd11, 3, 1, 1'b0, "R2");

      // R5: corrupted CRC, nothing written, sticky flag, then clear (R10)
      wd[0] = 8'h11; wd[1] = 8'h22;
      write_frame(DEV, 6'd20, 2, 1'b1, 8'h00, -1, 1'b0, "R5");
      chk("R5", "err_crc set", {31'd0, err_crc}, 1);
      chk("R5", "err_range clear", {31'd0, err_range}, 0);
      read_frame(6'd20, 2, 0, 1'b0, "R5");
      chk("R5", "err_crc still set", {31'd0, err_crc}, 1);
      @(negedge clk); err_clr = 1'b1;
      @(negedge clk); err_clr = 1'b0;
      chk("R10", "err_crc after clear", {31'd0, err_crc}, 0);

      // R6: stop after two of three data bytes
      wd[0] = 8'h55; wd[1] = 8'h66; wd[2] = 8'h77;
      write_frame(DEV, 6'd30, 3, 1'b0, 8'h00, 2, 1'b0, "R6");
      chk("R6", "err_crc after abort", {31'd0, err_crc}, 0);
      read_frame(6'd30, 3, 0, 1'b0, "R6");

      // R1: valid frame for another device address
      wd[0] = 8'h99;
      write_frame(OTHER, 6'd5, 1, 1'b0, 8'h00, -1, 1'b0, "R1");
      pulse_start;
      send({OTHER, 1'b1});
      take(b);
      chk("R1", "foreign read byte", {24'd0, b}, 32'hFF);
      pulse_stop;
      read_frame(6'd5, 1, 0, 1'b0, "R1");

      // R8: burst running past the last register
      wd[0] = 8'h01; wd[1] = 8'h02; wd[2] = 8'h03; wd[3] = 8'h04;
      write_frame(DEV, 6'd46, 4, 1'b0, 8'h00, -1, 1'b0, "R8");
      chk("R8", "err_range set", {31'd0, err_range}, 1);
      read_frame(6'd46, 4, 0, 1'b1, "R8");
      @(negedge clk); err_clr = 1'b1;
      @(negedge clk); err_clr = 1'b0;
      chk("R10", "err_range after clear", {31'd0, err_range}, 0);
      // R8: burst ending exactly on the last register is legal
      wd[0] = 8'hE1; wd[1] = 8'hE2; wd[2] = 8'hE3; wd[3] = 8'hE4;
      write_frame(DEV, 6'd44, 4, 1'b0, 8'h00, -1, 1'b1, "R8");
      chk("R8", "err_range at boundary", {31'd0, err_range}, 0);
      read_frame(6'd44, 4, 0, 1'b0, "R8");

      // R9: read with no register address since the last stop
      pulse_start;
      send({DEV, 1'b1});
      chk("R9", "selected", {31'd0, selected}, 1);
      take(b);
      chk("R9", "first byte", {24'd0, b}, 32'hFF);
      take(b);
      chk("R9", "second byte", {24'd0, b}, 32'hFF);
      pulse_stop;

      idle(4);
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end
endmodule